// File: doc/BRIEF.md
# Cartridge ROM Bank Controller

This block sits between a CPU's ROM address space and a cartridge ROM that is larger than the 32 KB the CPU can see directly. While reset is held, it captures an 8-bit cartridge type code and turns it into one of six banking behaviours. After reset, CPU writes into the ROM address range are not stored anywhere. Writes to the bank-select range are read as commands that load a new number into the bank register.

On the read side, the lower 16 KB window (0x0000-0x3FFF) always shows ROM bank 0. The upper 16 KB window (0x4000-0x7FFF) shows the bank currently selected. The block turns the CPU read address into a physical ROM byte address. It also raises a select flag for any read inside the ROM space.

The size of the ROM is given as log2 of its bank count, where one bank is 16 KB. A bank request that would point past the end of the ROM is dropped without effect.

Top module: `cart_bank_ctrl`

## Requirements
- R1: The type code is captured on each clock edge while `rst_n` is low and is never captured after that. Codes 0x00, 0x08 and 0x09 select the fixed behaviour. Codes 0x01-0x03 select the five-bit behaviour. Codes 0x05-0x06 and 0x15-0x17 select the two locked behaviours. Codes 0x0F-0x13 select the seven-bit non-zero behaviour. Codes 0x19-0x1E select the seven-bit raw behaviour.
- R2: At the first clock edge that sees `rst_n` low, the bank register becomes 1.
- R3: A write issues a bank command only when `wr_addr[15:13]` equals 3'b001, which is the range 0x2000-0x3FFF. Writes to any other address leave the bank unchanged.
- R4: The five-bit behaviour takes `wr_data[4:0]` and turns a value of 0 into 1. It then ORs in bits 6:5 of the current bank. Because bits 6:5 start at 0 after reset, they stay 0.
- R5: The seven-bit non-zero behaviour takes `wr_data[6:0]` and turns a value of 0 into 1.
- R6: The seven-bit raw behaviour takes `wr_data[6:0]` unchanged, so bank 0 can be selected in the upper window.
- R7: A request for bank b is accepted only if b < 2^`size_log2`. If it is not, the bank register keeps its previous value.
- R8: Under the fixed behaviour and both locked behaviours, every write leaves the bank unchanged.
- R9: For `rd_addr` in 0x4000-0x7FFF, `rom_addr` is bank×0x4000 + `rd_addr[13:0]`. For 0x0000-0x3FFF it is `rd_addr[13:0]`. In both cases `rom_sel` is 1. For reads at 0x8000 and above, `rom_sel` is 0 and `rom_addr` is 0.
- R10: Any type code not listed in R1 selects the seven-bit raw behaviour. Examples are 0x04, 0x07, 0x14 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the type code is captured while it is low |
| type_code | input | 8 | Cartridge type code from the header |
| size_log2 | input | 3 | log2 of the ROM size in 16 KB banks |
| wr_en | input | 1 | CPU write strobe, sampled on the rising edge |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rd_addr | input | 16 | CPU read address |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_sel | output | 1 | Read falls inside ROM space |

## Verification
A write that is held across one rising edge updates the bank register at that edge. Because `rom_addr` is combinational from the bank register and `rd_addr`, the new bank is visible before the next edge. The bench therefore drives the write at a falling edge and removes it at the following falling edge. It samples `rom_addr` 1 ns later, when exactly one register update has happened.

Read-side checks change only `rd_addr` and are sampled 1 ns after it settles, with no clock edge in between. Type-code capture is checked by changing `type_code` after reset and confirming that the behaviour does not change.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    typedef enum logic [2:0] {
        KIND_FIXED     = 3'd0,
        KIND_LOW5_KEEP = 3'd1,
        KIND_LOCKED_B  = 3'd2,
        KIND_LOW7_NZ   = 3'd3,
        KIND_LOCKED_D  = 3'd4,
        KIND_LOW7_RAW  = 3'd5
    } bank_kind_e;

    function automatic logic kind_is_inert(bank_kind_e k);
        return (k == KIND_FIXED) || (k == KIND_LOCKED_B) || (k == KIND_LOCKED_D);
    endfunction

endpackage

// File: rtl/cbc_kind_decode.sv
module cbc_kind_decode
    import cbc_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code,
    output bank_kind_e        kind
);

    always_comb begin
        unique case (code)
            8'h00, 8'h08, 8'h09:                      kind = KIND_FIXED;
            8'h01, 8'h02, 8'h03:                      kind = KIND_LOW5_KEEP;
            8'h05, 8'h06:                             kind = KIND_LOCKED_B;
            8'h0F, 8'h10, 8'h11, 8'h12, 8'h13:        kind = KIND_LOW7_NZ;
            8'h15, 8'h16, 8'h17:                      kind = KIND_LOCKED_D;
            default:                                  kind = KIND_LOW7_RAW;
        endcase
    end

endmodule

// File: rtl/cbc_bank_calc.sv
module cbc_bank_calc
    import cbc_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 7,
    parameter int NARROW_W = 5,
    parameter int SIZE_W   = 3
) (
    input  bank_kind_e        kind,
    input  logic [BANK_W-1:0] cur_bank,
    input  logic [DATA_W-1:0] data,
    input  logic [SIZE_W-1:0] size_log2,
    output logic [BANK_W-1:0] req_bank,
    output logic              accept
);

    localparam int KEEP_W = BANK_W - NARROW_W;

    logic [BANK_W-1:0]   narrow_val;
    logic [BANK_W-1:0]   wide_val;
    logic [BANK_W-1:0]   keep_bits;
    logic                fits;
    logic                unused_hi;

    assign unused_hi = ^data[DATA_W-1:BANK_W];

    always_comb begin
        narrow_val = {{KEEP_W{1'b0}}, data[NARROW_W-1:0]};
        if (narrow_val == '0) begin
            narrow_val = {{(BANK_W-1){1'b0}}, 1'b1};
        end
        keep_bits = {cur_bank[BANK_W-1:NARROW_W], {NARROW_W{1'b0}}};
        wide_val  = data[BANK_W-1:0];
    end

    always_comb begin
        req_bank = cur_bank;
        unique case (kind)
            KIND_LOW5_KEEP: req_bank = narrow_val | keep_bits;
            KIND_LOW7_NZ:   req_bank = (wide_val == '0) ? {{(BANK_W-1){1'b0}}, 1'b1} : wide_val;
            KIND_LOW7_RAW:  req_bank = wide_val;
            default:        req_bank = cur_bank;
        endcase
    end

    assign fits   = ((req_bank >> size_log2) == '0);
    assign accept = !kind_is_inert(kind) && fits;

endmodule

// File: rtl/cbc_addr_map.sv
module cbc_addr_map #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 7,
    parameter int WIN_W  = 14
) (
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [BANK_W-1:0]       bank,
    output logic [BANK_W+WIN_W-1:0] rom_addr,
    output logic                    rom_sel
);

    logic [ADDR_W-WIN_W-1:0] region;

    assign region = rd_addr[ADDR_W-1:WIN_W];

    always_comb begin
        rom_addr = '0;
        rom_sel  = 1'b0;
        if (region == 'd0) begin
            rom_addr = {{BANK_W{1'b0}}, rd_addr[WIN_W-1:0]};
            rom_sel  = 1'b1;
        end else if (region == 'd1) begin
            rom_addr = {bank, rd_addr[WIN_W-1:0]};
            rom_sel  = 1'b1;
        end
    end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int CODE_W   = 8,
    parameter int BANK_W   = 7,
    parameter int NARROW_W = 5,
    parameter int WIN_W    = 14,
    parameter int SEL_W    = 3,
    parameter int SEL_CMD  = 1,
    localparam int SIZE_W  = $clog2(BANK_W + 1),
    localparam int ROM_AW  = BANK_W + WIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] type_code,
    input  logic [SIZE_W-1:0] size_log2,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_sel
);

    typedef struct packed {
        bank_kind_e        kind;
        logic [BANK_W-1:0] bank;
    } ctrl_state_t;

    ctrl_state_t       state_d, state_q;
    bank_kind_e        dec_kind;
    logic [BANK_W-1:0] req_bank;
    logic              accept;
    logic              cmd_hit;
    logic              unused_wr_low;

    assign unused_wr_low = ^wr_addr[ADDR_W-SEL_W-1:0];

    cbc_kind_decode #(.CODE_W(CODE_W)) u_decode (
        .code (type_code),
        .kind (dec_kind)
    );

    cbc_bank_calc #(
        .DATA_W   (DATA_W),
        .BANK_W   (BANK_W),
        .NARROW_W (NARROW_W),
        .SIZE_W   (SIZE_W)
    ) u_calc (
        .kind      (state_q.kind),
        .cur_bank  (state_q.bank),
        .data      (wr_data),
        .size_log2 (size_log2),
        .req_bank  (req_bank),
        .accept    (accept)
    );

    cbc_addr_map #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .WIN_W  (WIN_W)
    ) u_map (
        .rd_addr  (rd_addr),
        .bank     (state_q.bank),
        .rom_addr (rom_addr),
        .rom_sel  (rom_sel)
    );

    assign cmd_hit = wr_en && (wr_addr[ADDR_W-1 -: SEL_W] == SEL_W'(SEL_CMD));

    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d.kind = dec_kind;
            state_d.bank = {{(BANK_W-1){1'b0}}, 1'b1};
        end else if (cmd_hit && accept) begin
            state_d.bank = req_bank;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk
    import cbc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 7,
    parameter int WIN_W  = 14,
    parameter int SIZE_W = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input bank_kind_e              kind,
    input logic [BANK_W-1:0]       bank,
    input logic [SIZE_W-1:0]       size_log2,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic [ADDR_W-1:0]       rd_addr,
    input logic [BANK_W+WIN_W-1:0] rom_addr,
    input logic                    rom_sel
);

    p_no_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr[ADDR_W-1 -: 3] == 3'b001) |=> $stable(bank));

    p_narrow_nz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == KIND_LOW5_KEEP && !$stable(bank)) |->
            (bank[4:0] != 5'd0 && bank[BANK_W-1:5] == $past(bank[BANK_W-1:5])));

    p_wide_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == KIND_LOW7_NZ && !$stable(bank)) |-> (bank != '0));

    p_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank) |-> ((bank >> $past(size_log2)) == '0));

    p_inert_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        kind_is_inert(kind) |=> $stable(bank));

    p_window_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[ADDR_W-1:WIN_W] == 2'b01) |->
            (rom_sel && rom_addr[WIN_W-1:0] == rd_addr[WIN_W-1:0]
             && rom_addr[BANK_W+WIN_W-1:WIN_W] == bank));

endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .WIN_W  (WIN_W),
    .SIZE_W (SIZE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (state_q.kind),
    .bank      (state_q.bank),
    .size_log2 (size_log2),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .rom_addr  (rom_addr),
    .rom_sel   (rom_sel)
);

// File: tb/cart_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  type_code = 8'h00;
    logic [2:0]  size_log2 = 3'd7;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = 16'h0000;
    logic [7:0]  wr_data = 8'h00;
    logic [15:0] rd_addr = 16'h0000;
    logic [20:0] rom_addr;
    logic        rom_sel;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cart_bank_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .type_code (type_code),
        .size_log2 (size_log2),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rom_addr  (rom_addr),
        .rom_sel   (rom_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic apply_reset(input logic [7:0] code, input logic [2:0] sz);
        @(negedge clk);
        rst_n = 1'b0; type_code = code; size_log2 = sz; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_rom(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_bank(input logic [6:0] b, input string tag);
        rd_addr = 16'h4000;
        #1;
        chk(tag, {11'd0, rom_addr}, {11'd0, b, 14'h0});
    endtask

    task automatic t_reset_state();
        apply_reset(8'h01, 3'd7);
        expect_bank(7'd1, "R2 bank after reset");
        rd_addr = 16'h4123; #1;
        chk("R9 upper window", {11'd0, rom_addr}, 32'h4123);
        rd_addr = 16'h1234; #1;
        chk("R9 fixed window", {11'd0, rom_addr}, 32'h1234);
        chk("R9 fixed window sel", {31'd0, rom_sel}, 32'd1);
        rd_addr = 16'h8000; #1;
        chk("R9 outside rom sel", {31'd0, rom_sel}, 32'd0);
        chk("R9 outside rom addr", {11'd0, rom_addr}, 32'd0);
    endtask

    task automatic t_variant_a();
        apply_reset(8'h02, 3'd7);
        write_rom(16'h2000, 8'h00); expect_bank(7'd1,  "R4 zero becomes one");
        write_rom(16'h2000, 8'h1F); expect_bank(7'h1F, "R4 max five bits");
        write_rom(16'h2000, 8'hE3); expect_bank(7'd3,  "R4 high data bits dropped");
        write_rom(16'h2000, 8'h60); expect_bank(7'd1,  "R4 upper bits kept at zero");
    endtask

    task automatic t_variant_c();
        apply_reset(8'h11, 3'd7);
        write_rom(16'h2000, 8'h7F); expect_bank(7'h7F, "R5 max seven bits");
        write_rom(16'h2000, 8'h00); expect_bank(7'd1,  "R5 zero becomes one");
        write_rom(16'h2000, 8'h80); expect_bank(7'd1,  "R5 masked zero becomes one");
        write_rom(16'h2000, 8'h85); expect_bank(7'd5,  "R5 bit7 dropped");
    endtask

    task automatic t_variant_e();
        apply_reset(8'h1B, 3'd7);
        write_rom(16'h2000, 8'h00); expect_bank(7'd0,  "R6 bank zero allowed");
        write_rom(16'h2000, 8'h7F); expect_bank(7'h7F, "R6 max seven bits");
        write_rom(16'h2000, 8'hC2); expect_bank(7'h42, "R6 bit7 dropped");
        type_code = 8'h00;
        write_rom(16'h2000, 8'h00); expect_bank(7'd0,  "R1 code ignored after reset");
    endtask

    task automatic t_fallback();
        apply_reset(8'h04, 3'd7);
        write_rom(16'h2000, 8'h00); expect_bank(7'd0,  "R10 code 04 allows zero");
        apply_reset(8'hFF, 3'd7);
        write_rom(16'h2000, 8'h44); expect_bank(7'h44, "R10 code FF seven bits");
        write_rom(16'h2000, 8'h00); expect_bank(7'd0,  "R10 code FF allows zero");
    endtask

    task automatic t_inert();
        logic [7:0] codes [8] = '{8'h00, 8'h08, 8'h09, 8'h05, 8'h06, 8'h15, 8'h16, 8'h17};
        foreach (codes[i]) begin
            apply_reset(codes[i], 3'd7);
            write_rom(16'h2000, 8'h05);
            write_rom(16'h3FFF, 8'h00);
            expect_bank(7'd1, $sformatf("R8 R1 code %0h ignores writes", codes[i]));
        end
    endtask

    task automatic t_decode_addr();
        apply_reset(8'h19, 3'd7);
        write_rom(16'h0000, 8'h05); expect_bank(7'd1, "R3 write at 0000 ignored");
        write_rom(16'h1FFF, 8'h05); expect_bank(7'd1, "R3 write at 1FFF ignored");
        write_rom(16'h4000, 8'h05); expect_bank(7'd1, "R3 write at 4000 ignored");
        write_rom(16'h7FFF, 8'h05); expect_bank(7'd1, "R3 write at 7FFF ignored");
        write_rom(16'hA000, 8'h05); expect_bank(7'd1, "R3 write at A000 ignored");
        write_rom(16'h3FFF, 8'h06); expect_bank(7'd6, "R3 write at 3FFF selects");
    endtask

    task automatic t_range();
        apply_reset(8'h13, 3'd3);
        write_rom(16'h2000, 8'h07); expect_bank(7'd7, "R7 last bank accepted");
        write_rom(16'h2000, 8'h08); expect_bank(7'd7, "R7 one past end rejected");
        write_rom(16'h2000, 8'h40); expect_bank(7'd7, "R7 far past end rejected");
        write_rom(16'h2000, 8'h00); expect_bank(7'd1, "R7 remapped one accepted");
        apply_reset(8'h01, 3'd2);
        write_rom(16'h2000, 8'h04); expect_bank(7'd1, "R7 five-bit past end rejected");
        write_rom(16'h2000, 8'h03); expect_bank(7'd3, "R7 five-bit in range");
        apply_reset(8'h1A, 3'd0);
        write_rom(16'h2000, 8'h00); expect_bank(7'd0, "R7 single bank zero accepted");
        write_rom(16'h2000, 8'h01); expect_bank(7'd0, "R7 single bank one rejected");
    endtask

    task automatic t_window();
        apply_reset(8'h1E, 3'd7);
        write_rom(16'h2000, 8'h2A);
        rd_addr = 16'h7FFF; #1;
        chk("R9 window top byte", {11'd0, rom_addr}, 32'hABFFF);
        rd_addr = 16'h3FFF; #1;
        chk("R9 fixed window unaffected", {11'd0, rom_addr}, 32'h3FFF);
    endtask

    initial begin
        t_reset_state();
        t_variant_a();
        t_variant_c();
        t_variant_e();
        t_fallback();
        t_inert();
        t_decode_addr();
        t_range();
        t_window();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule